// File: doc/BRIEF.md
# Bus Window Decoder

This block is the slave-side front end of a 32-bit memory-mapped bus port. The incoming word address (byte address bits 11 down to 2) is sorted into one of three windows: a control-register bank in the lowest kilobyte, a descriptor memory in the second kilobyte, and an unpopulated upper two kilobytes. The block drives a chip select towards the register back end or the descriptor back end. It steers the matching read data onto the bus, and it answers the master with an acknowledge or an error. The contents of both back ends lie outside the block.

Each bus cycle is sorted by a combinational classifier into one named window class:
- `WIN_IDLE`: no strobed cycle.
- `WIN_BADSEL`: a partial byte select.
- `WIN_REGS`: the register window.
- `WIN_DESC`: the descriptor window.
- `WIN_DESC_LOCKED`: the descriptor window while the soft reset is high.
- `WIN_HOLE`: the upper hole.

The class can move from any value to any other on every cycle, because it follows the inputs directly.

The parameter `REGISTERED_OUT` selects how the response is driven. When it is 1, the response goes through a small state machine with the states `RSP_IDLE`, `RSP_ACK` and `RSP_ERR`, and the data is registered.
- From `RSP_IDLE`, the machine goes to `RSP_ERR` on a combinational error, to `RSP_ACK` on a combinational acknowledge, and otherwise stays.
- From `RSP_ACK`, it goes to `RSP_ERR` on an error, and otherwise returns to `RSP_IDLE`. A second acknowledge is blocked.
- From `RSP_ERR`, it goes to `RSP_ACK` on an acknowledge, and otherwise returns to `RSP_IDLE`. A second error is blocked.

As a result, every indication is a single-cycle pulse. When `REGISTERED_OUT` is 0, the combinational response drives the outputs directly.

Top module: `bus_window_decoder`

## Requirements
- R1: A strobed cycle (`stb_i` and `cyc_i` both high) whose `sel_i` is not 4'b1111 raises error and asserts neither chip select nor acknowledge.
- R2: A strobed full-word cycle with `adr_i[9:8]` = 2'b00 (byte range 0x000-0x3FF) asserts `reg_cs_o` and acknowledges in the same cycle, without error.
- R3: A strobed full-word cycle with `adr_i[9:8]` = 2'b01 (byte range 0x400-0x7FF) and soft reset low asserts `desc_cs_o`. In that case acknowledge follows `desc_ack_i`. At most one chip select is ever high.
- R4: A strobed full-word cycle with `adr_i[9]` = 1 (byte range 0x800-0xFFF) raises error, with no acknowledge and no chip select.
- R5: While `soft_rst_i` is high, a descriptor-window cycle raises error, keeps `desc_cs_o` low and gives no acknowledge. Register-window cycles are unaffected.
- R6: Read data is `reg_rdata_i` when the register window is selected on a read (`we_i` = 0). In every other case it is `desc_rdata_i`.
- R7: With `stb_i` or `cyc_i` low, no chip select, acknowledge or error is asserted.
- R8: With `REGISTERED_OUT` = 1, acknowledge, error and data appear one clock after the cycle is presented. Acknowledge and error are never high on two consecutive clocks, even when the strobe is held.
- R9: `rst` clears the registered acknowledge, error and data to zero.
- R10: Both back ends receive `adr_i[7:0]` as their word index in every cycle.
- R11: With `REGISTERED_OUT` = 0, acknowledge, error and data follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Bus reset, active high, asynchronous |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Strobe for this slave |
| we_i | input | 1 | Write (1) or read (0) |
| sel_i | input | 4 | Byte lane selects |
| adr_i | input | 10 | Word address, byte address bits 11..2 |
| soft_rst_i | input | 1 | Soft reset of the descriptor path |
| dat_o | output | 32 | Read data to the master |
| ack_o | output | 1 | Acknowledge |
| err_o | output | 1 | Error response |
| reg_cs_o | output | 1 | Register back end select |
| reg_idx_o | output | 8 | Register word index |
| reg_rdata_i | input | 32 | Register back end read data |
| desc_cs_o | output | 1 | Descriptor back end select |
| desc_idx_o | output | 8 | Descriptor word index |
| desc_ack_i | input | 1 | Descriptor back end acknowledge |
| desc_rdata_i | input | 32 | Descriptor back end read data |

## Verification
The bench builds two copies side by side, one with `REGISTERED_OUT` = 1 and one with `REGISTERED_OUT` = 0. Both copies receive identical stimulus, so a single expected-value model covers the one-clock-late pulse behaviour and the same-cycle pass-through behaviour. The registered copy makes held strobes and a reset arriving during an access observable: a held strobe must give a pulse that does not repeat, and the reset must clear a pending pulse. The combinational copy exposes the chip selects and indices in the very cycle of the access.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    // Window class of the cycle presented on the bus
    typedef enum logic [2:0] {
        WIN_IDLE        = 3'd0,
        WIN_BADSEL      = 3'd1,
        WIN_REGS        = 3'd2,
        WIN_DESC        = 3'd3,
        WIN_DESC_LOCKED = 3'd4,
        WIN_HOLE        = 3'd5
    } win_e;

    // Registered response state: bit 0 acknowledge, bit 1 error
    typedef enum logic [1:0] {
        RSP_IDLE = 2'b00,
        RSP_ACK  = 2'b01,
        RSP_ERR  = 2'b10
    } rsp_e;

    // Upper two word-address bits that pick the window
    localparam logic [1:0] REGION_REGS = 2'b00;
    localparam logic [1:0] REGION_DESC = 2'b01;

endpackage

// File: rtl/bwd_window_classify.sv
module bwd_window_classify
    import bwd_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter int ADR_W = 10
) (
    input  logic             cyc_i,
    input  logic             stb_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [ADR_W-1:0] adr_i,
    input  logic             soft_rst_i,
    output win_e             win_o,
    output logic             reg_cs_o,
    output logic             desc_cs_o,
    output logic             err_o
);

    logic       active;
    logic       full_word;
    logic [1:0] region;
    win_e       win;

    assign active    = cyc_i & stb_i;
    assign full_word = &sel_i;
    assign region    = adr_i[ADR_W-1 -: 2];

    // Classify the current cycle
    always_comb begin
        if (!active) begin
            win = WIN_IDLE;
        end else if (!full_word) begin
            win = WIN_BADSEL;
        end else if (region == REGION_REGS) begin
            win = WIN_REGS;
        end else if (region == REGION_DESC) begin
            win = soft_rst_i ? WIN_DESC_LOCKED : WIN_DESC;
        end else begin
            win = WIN_HOLE;
        end
    end

    // Per-class outputs
    always_comb begin
        reg_cs_o  = 1'b0;
        desc_cs_o = 1'b0;
        err_o     = 1'b0;
        unique case (win)
            WIN_IDLE:        ;
            WIN_REGS:        reg_cs_o  = 1'b1;
            WIN_DESC:        desc_cs_o = 1'b1;
            WIN_BADSEL,
            WIN_DESC_LOCKED,
            WIN_HOLE:        err_o     = 1'b1;
            default:         ;
        endcase
    end

    assign win_o = win;

endmodule

// File: rtl/bwd_resp_stage.sv
module bwd_resp_stage
    import bwd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_i,
    input  logic              err_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic              ack_o,
    output logic              err_o,
    output logic [DATA_W-1:0] dat_o
);

    generate
        if (REGISTERED) begin : g_reg
            rsp_e              state_q;
            rsp_e              state_d;
            logic [DATA_W-1:0] dat_q;

            // State register
            always_ff @(posedge clk or posedge rst) begin
                if (rst) state_q <= RSP_IDLE;
                else     state_q <= state_d;
            end

            // Next state: a response that is showing now cannot repeat
            always_comb begin
                state_d = RSP_IDLE;
                unique case (state_q)
                    RSP_IDLE: begin
                        if (err_i)      state_d = RSP_ERR;
                        else if (ack_i) state_d = RSP_ACK;
                    end
                    RSP_ACK: begin
                        if (err_i)      state_d = RSP_ERR;
                    end
                    RSP_ERR: begin
                        if (ack_i)      state_d = RSP_ACK;
                    end
                    default:            state_d = RSP_IDLE;
                endcase
            end

            always_ff @(posedge clk or posedge rst) begin
                if (rst) dat_q <= '0;
                else     dat_q <= dat_i;
            end

            // Outputs
            always_comb begin
                ack_o = (state_q == RSP_ACK);
                err_o = (state_q == RSP_ERR);
                dat_o = dat_q;
            end

            assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
                ack_o |=> !ack_o);
            assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
                err_o |=> !err_o);
            assert_ack_cause_R8: assert property (@(posedge clk) disable iff (rst)
                ack_o |-> $past(ack_i));
            assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
                err_o |-> $past(err_i));
        end else begin : g_comb
            always_comb begin
                ack_o = ack_i;
                err_o = err_i;
                dat_o = dat_i;
            end
        end
    endgenerate

endmodule

// File: rtl/bus_window_decoder.sv
module bus_window_decoder
    import bwd_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int ADR_W          = 10,
    parameter bit REGISTERED_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cyc_i,
    input  logic                  stb_i,
    input  logic                  we_i,
    input  logic [DATA_W/8-1:0]   sel_i,
    input  logic [ADR_W-1:0]      adr_i,
    input  logic                  soft_rst_i,
    output logic [DATA_W-1:0]     dat_o,
    output logic                  ack_o,
    output logic                  err_o,
    output logic                  reg_cs_o,
    output logic [ADR_W-3:0]      reg_idx_o,
    input  logic [DATA_W-1:0]     reg_rdata_i,
    output logic                  desc_cs_o,
    output logic [ADR_W-3:0]      desc_idx_o,
    input  logic                  desc_ack_i,
    input  logic [DATA_W-1:0]     desc_rdata_i
);

    localparam int SEL_W = DATA_W / 8;
    localparam int IDX_W = ADR_W - 2;

    win_e              win;
    logic              ack_c;
    logic              err_c;
    logic [DATA_W-1:0] dat_c;

    bwd_window_classify #(
        .SEL_W (SEL_W),
        .ADR_W (ADR_W)
    ) i_classify (
        .cyc_i      (cyc_i),
        .stb_i      (stb_i),
        .sel_i      (sel_i),
        .adr_i      (adr_i),
        .soft_rst_i (soft_rst_i),
        .win_o      (win),
        .reg_cs_o   (reg_cs_o),
        .desc_cs_o  (desc_cs_o),
        .err_o      (err_c)
    );

    assign reg_idx_o  = adr_i[IDX_W-1:0];
    assign desc_idx_o = adr_i[IDX_W-1:0];

    // Combinational response and read-data steering
    assign ack_c = reg_cs_o | (desc_cs_o & desc_ack_i);
    assign dat_c = (reg_cs_o & ~we_i) ? reg_rdata_i : desc_rdata_i;

    bwd_resp_stage #(
        .DATA_W     (DATA_W),
        .REGISTERED (REGISTERED_OUT)
    ) i_resp (
        .clk   (clk),
        .rst   (rst),
        .ack_i (ack_c),
        .err_i (err_c),
        .dat_i (dat_c),
        .ack_o (ack_o),
        .err_o (err_o),
        .dat_o (dat_o)
    );

    assert_partial_err_R1: assert property (@(posedge clk) disable iff (rst)
        (stb_i && cyc_i && !(&sel_i)) |-> (err_c && !ack_c && !reg_cs_o && !desc_cs_o));
    assert_regs_ack_R2: assert property (@(posedge clk) disable iff (rst)
        (stb_i && cyc_i && (&sel_i) && adr_i[ADR_W-1 -: 2] == REGION_REGS)
            |-> (reg_cs_o && ack_c && !err_c));
    assert_one_select_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_cs_o, desc_cs_o}));
    assert_hole_err_R4: assert property (@(posedge clk) disable iff (rst)
        (stb_i && cyc_i && adr_i[ADR_W-1]) |-> (err_c && !ack_c));
    assert_locked_desc_R5: assert property (@(posedge clk) disable iff (rst)
        soft_rst_i |-> !desc_cs_o);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !(stb_i && cyc_i) |-> (!reg_cs_o && !desc_cs_o && !ack_c && !err_c && win == WIN_IDLE));

endmodule

// File: tb/test_bus_window_decoder.sv
module test_bus_window_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc = 1'b0;
    logic       stb = 1'b0;
    logic       we  = 1'b0;
    logic [3:0] sel = 4'h0;
    logic [9:0] adr = '0;
    logic       srst = 1'b0;
    logic       rdy  = 1'b1;

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [31:0] reg_pat(input logic [7:0] i);
        return {16'hA5C3, i, ~i};
    endfunction
    function automatic logic [31:0] desc_pat(input logic [7:0] i);
        return {16'h5D1E, ~i, i};
    endfunction

    // Registered instance
    logic [31:0] r_dat;
    logic        r_ack, r_err, r_rcs, r_dcs, r_dack;
    logic [7:0]  r_ridx, r_didx;
    assign r_dack = r_dcs & rdy;

    bus_window_decoder #(.REGISTERED_OUT(1'b1)) i_bus_window_decoder (
        .clk(clk), .rst(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we), .sel_i(sel),
        .adr_i(adr), .soft_rst_i(srst), .dat_o(r_dat), .ack_o(r_ack), .err_o(r_err),
        .reg_cs_o(r_rcs), .reg_idx_o(r_ridx), .reg_rdata_i(reg_pat(r_ridx)),
        .desc_cs_o(r_dcs), .desc_idx_o(r_didx), .desc_ack_i(r_dack),
        .desc_rdata_i(desc_pat(r_didx))
    );

    // Combinational instance
    logic [31:0] c_dat;
    logic        c_ack, c_err, c_rcs, c_dcs, c_dack;
    logic [7:0]  c_ridx, c_didx;
    assign c_dack = c_dcs & rdy;

    bus_window_decoder #(.REGISTERED_OUT(1'b0)) i_bus_window_decoder_comb (
        .clk(clk), .rst(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we), .sel_i(sel),
        .adr_i(adr), .soft_rst_i(srst), .dat_o(c_dat), .ack_o(c_ack), .err_o(c_err),
        .reg_cs_o(c_rcs), .reg_idx_o(c_ridx), .reg_rdata_i(reg_pat(c_ridx)),
        .desc_cs_o(c_dcs), .desc_idx_o(c_didx), .desc_ack_i(c_dack),
        .desc_rdata_i(desc_pat(c_didx))
    );

    typedef struct {
        string       tag;
        logic        c_ack, c_err, c_rcs, c_dcs;
        logic [31:0] c_dat;
        logic [7:0]  idx;
        logic        r_ack, r_err;
        logic [31:0] r_dat;
    } item_t;

    item_t q[$];
    int    vectors = 0;
    int    miscompares = 0;
    logic  last_a = 1'b0;
    logic  last_e = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: present one cycle at the falling edge, push what must be seen
    task automatic drive(input logic s, input logic c, input logic w,
                         input logic [3:0] se, input logic [9:0] a,
                         input logic sr, input logic rd, input logic rs,
                         input string tag);
        item_t it;
        logic act, full;
        @(negedge clk);
        stb = s; cyc = c; we = w; sel = se; adr = a; srst = sr; rdy = rd; rst = rs;
        act  = s && c;
        full = (se == 4'hF);
        it.tag   = tag;
        it.idx   = a[7:0];
        it.c_rcs = act && full && a[9:8] == 2'b00;
        it.c_dcs = act && full && a[9:8] == 2'b01 && !sr;
        it.c_ack = it.c_rcs || (it.c_dcs && rd);
        it.c_err = act && (!full || a[9] || (a[9:8] == 2'b01 && sr));
        it.c_dat = (it.c_rcs && !w) ? reg_pat(a[7:0]) : desc_pat(a[7:0]);
        if (rs) begin
            it.r_ack = 1'b0; it.r_err = 1'b0; it.r_dat = '0;
        end else begin
            it.r_ack = it.c_ack && !last_a;
            it.r_err = it.c_err && !last_e;
            it.r_dat = it.c_dat;
        end
        last_a = it.r_ack;
        last_e = it.r_err;
        q.push_back(it);
    endtask

    // Monitor: compare after the following rising edge has settled
    always @(posedge clk) begin
        #2;
        if (q.size() != 0) begin
            item_t it;
            it = q.pop_front();
            chk(it.tag, "comb ack",  {31'd0, c_ack}, {31'd0, it.c_ack});
            chk(it.tag, "comb err",  {31'd0, c_err}, {31'd0, it.c_err});
            chk(it.tag, "comb data", c_dat, it.c_dat);
            chk(it.tag, "reg cs",    {31'd0, c_rcs}, {31'd0, it.c_rcs});
            chk(it.tag, "desc cs",   {31'd0, c_dcs}, {31'd0, it.c_dcs});
            chk(it.tag, "reg idx R10",  {24'd0, c_ridx}, {24'd0, it.idx});
            chk(it.tag, "desc idx R10", {24'd0, r_didx}, {24'd0, it.idx});
            chk(it.tag, "regd ack",  {31'd0, r_ack}, {31'd0, it.r_ack});
            chk(it.tag, "regd err",  {31'd0, r_err}, {31'd0, it.r_err});
            chk(it.tag, "regd data", r_dat, it.r_dat);
        end
    end

    initial begin : watchdog
        #(8 * 100000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // reset state, R9
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 1, "R9 reset idle");
        drive(1, 1, 0, 4'hF, 10'h011, 0, 1, 1, "R9 access under reset");
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 0, "R7 idle after reset");
        // register window, R2 R6 R10 R11
        drive(1, 1, 0, 4'hF, 10'h005, 0, 1, 0, "R2 reg read");
        drive(0, 0, 0, 4'hF, 10'h005, 0, 1, 0, "R7 idle");
        drive(1, 1, 1, 4'hF, 10'h0FF, 0, 1, 0, "R6 reg write data from desc port");
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 0, "R7 idle");
        // descriptor window, R3
        drive(1, 1, 0, 4'hF, 10'h13C, 0, 1, 0, "R3 desc read acked");
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 0, "R7 idle");
        drive(1, 1, 0, 4'hF, 10'h1A7, 0, 0, 0, "R3 desc wait no ack");
        drive(1, 1, 0, 4'hF, 10'h1A7, 0, 1, 0, "R3 desc ack after wait");
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 0, "R7 idle");
        // soft reset, R5
        drive(1, 1, 0, 4'hF, 10'h142, 1, 1, 0, "R5 desc locked");
        drive(0, 0, 0, 4'h0, 10'h000, 1, 1, 0, "R7 idle");
        drive(1, 1, 0, 4'hF, 10'h042, 1, 1, 0, "R5 reg unaffected");
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 0, "R7 idle");
        // hole, R4
        drive(1, 1, 0, 4'hF, 10'h200, 0, 1, 0, "R4 hole low");
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 0, "R7 idle");
        drive(1, 1, 1, 4'hF, 10'h3FF, 0, 1, 0, "R4 hole top");
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 0, "R7 idle");
        // partial selects, R1
        drive(1, 1, 0, 4'h7, 10'h010, 0, 1, 0, "R1 partial reg");
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 0, "R7 idle");
        drive(1, 1, 1, 4'h0, 10'h120, 0, 1, 0, "R1 no lanes desc");
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 0, "R7 idle");
        // half a handshake, R7
        drive(1, 0, 0, 4'hF, 10'h200, 0, 1, 0, "R7 strobe only");
        drive(0, 1, 0, 4'h3, 10'h008, 0, 1, 0, "R7 cycle only");
        // held strobes, R8
        drive(1, 1, 0, 4'hF, 10'h021, 0, 1, 0, "R8 held ack first");
        drive(1, 1, 0, 4'hF, 10'h021, 0, 1, 0, "R8 held ack second");
        drive(1, 1, 0, 4'hF, 10'h021, 0, 1, 0, "R8 held ack third");
        drive(1, 1, 0, 4'hF, 10'h300, 0, 1, 0, "R8 ack then err");
        drive(1, 1, 0, 4'hF, 10'h300, 0, 1, 0, "R8 held err second");
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 0, "R7 idle");
        // reset over a pending pulse, R9
        drive(1, 1, 0, 4'hF, 10'h033, 0, 1, 1, "R9 reset over access");
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 0, "R9 release");
        drive(1, 1, 0, 4'hF, 10'h1F0, 0, 1, 0, "R11 desc read after reset");
        drive(0, 0, 0, 4'h0, 10'h000, 0, 1, 0, "R7 final idle");
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule